// File: doc/BRIEF.md
# Four-Stage Right-Shift Register with J-K Serial Entry

This block is a small synchronous register of four stages, named A through D. On each rising clock edge it does one of two things. It either captures a four-bit parallel word into all stages at once, or it moves the contents one place from stage A toward stage D. A single mode input picks between the two.

In shift mode, stage A does not take a plain serial bit. It takes its next value from a J input and an active-low K input. This lets the first stage act as a set/reset, D-type or toggle flip-flop. An active-low clear resets every stage at once, with no clock needed, and takes priority over everything else. The last stage drives a true output and an inverted output.

The block is used wherever a short word must be serialized or collected, or where a toggle or hold function is wanted at the head of a chain.

Top module: `jk_shift4`

## Requirements
- R1: When `shift_en` is 0 at a rising edge of `clk`, `q` takes the value of `par_d`. Bit 0 of each vector is stage A and bit 3 is stage D.
- R2: During a parallel load, the values on `j_in` and `k_n_in` have no effect on the loaded word.
- R3: When `shift_en` is 1 at a rising edge, stages 1 to 3 take the previous values of stages 0 to 2. During a shift, `par_d` has no effect.
- R4: During a shift, stage A's next value depends on `{j_in,k_n_in}`: 00 gives 0, 11 gives 1, 01 keeps stage A's previous value, and 10 inverts it.
- R5: While `clr_n` is 0, all stages are 0 at once, with no clock edge needed.
- R6: With no rising clock edge and no clear, the stages keep their values even when the data and control inputs change.
- R7: `q_last_n` is always the inverse of `q[3]`, including right after clear.
- R8: A clock edge that arrives while `clr_n` is 0 leaves all stages at 0. The first edge after release acts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift toward stage D, 0 = parallel load |
| j_in | input | 1 | J serial entry for stage A |
| k_n_in | input | 1 | K serial entry for stage A, active low |
| par_d | input | 4 | Parallel load word, bit 0 = stage A |
| q | output | 4 | Stage outputs, bit 0 = stage A |
| q_last_n | output | 1 | Inverse of stage D |

## Verification
Every stage is an output, so any wrong stage value shows on `q` at the sampling point right after the edge that caused it. A wrong J-K decode in stage A also travels down the chain and reappears on `q_last_n` three shifts later. This makes the hold and toggle cases visible twice. A clear that waits for the clock shows as nonzero outputs in the gap between the clear falling and the next edge.

// File: rtl/jksr_pkg.sv
package jksr_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } jksr_mode_e;

  // next value of the head stage from the J / active-low K pair
  function automatic logic jk_next(input logic j, input logic k_n, input logic cur);
    logic r;
    unique case ({j, k_n})
      2'b00:   r = 1'b0;
      2'b01:   r = cur;
      2'b10:   r = ~cur;
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/jksr_entry.sv
module jksr_entry (
  input  logic j,
  input  logic k_n,
  input  logic cur,
  output logic nxt
);
  import jksr_pkg::*;
  always_comb nxt = jk_next(j, k_n, cur);
endmodule

// File: rtl/jksr_stages.sv
module jksr_stages #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              shift_en,
  input  logic              head_bit,
  input  logic [STAGES-1:0] par_d,
  output logic [STAGES-1:0] q
);
  import jksr_pkg::*;
  localparam int LAST = STAGES - 1;

  jksr_mode_e        mode;
  logic [STAGES-1:0] q_r;
  logic [STAGES-1:0] q_nxt;
  logic              load_evt;
  logic              shift_evt;

  assign mode      = jksr_mode_e'(shift_en);
  assign load_evt  = (mode == MODE_LOAD);
  assign shift_evt = (mode == MODE_SHIFT);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign q_nxt[i] = shift_evt ? head_bit : par_d[i];
    end else begin : g_body
      assign q_nxt[i] = shift_evt ? q_r[i-1] : par_d[i];
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  p_load_capture_r1: assert property (@(posedge clk) disable iff (!clr_n)
    load_evt |=> q == $past(par_d));
  p_shift_chain_r3: assert property (@(posedge clk) disable iff (!clr_n)
    shift_evt |=> q[LAST:1] == $past(q[LAST-1:0]));
  p_clear_zero_r5: assert property (@(posedge clk)
    !clr_n |-> q == '0);
endmodule

// File: rtl/jk_shift4.sv
module jk_shift4 #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              shift_en,
  input  logic              j_in,
  input  logic              k_n_in,
  input  logic [STAGES-1:0] par_d,
  output logic [STAGES-1:0] q,
  output logic              q_last_n
);
  localparam int LAST = STAGES - 1;

  logic head_nxt;
  logic [STAGES-1:0] stage_q;

  jksr_entry u_entry (
    .j   (j_in),
    .k_n (k_n_in),
    .cur (stage_q[0]),
    .nxt (head_nxt)
  );

  jksr_stages #(.STAGES(STAGES)) u_stages (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .head_bit (head_nxt),
    .par_d    (par_d),
    .q        (stage_q)
  );

  assign q        = stage_q;
  assign q_last_n = ~stage_q[LAST];

  // R4: each J-K code checked separately
  p_entry_reset_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !j_in && !k_n_in) |=> q[0] == 1'b0);
  p_entry_set_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && j_in && k_n_in) |=> q[0] == 1'b1);
  p_entry_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !j_in && k_n_in) |=> $stable(q[0]));
  p_entry_toggle_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && j_in && !k_n_in) |=> q[0] != $past(q[0]));
  p_complement_r7: assert property (@(posedge clk) disable iff (!clr_n)
    q_last_n != q[LAST]);
endmodule

// File: tb/sim_jk_shift4.sv
module sim_jk_shift4;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;
  // {shift_en, j, k_n, par_d[3:0], expected q[3:0]}
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b010, 4'b1010, 4'b1010},  // R1 R2 load
    {3'b001, 4'b0101, 4'b0101},  // R1 R2 load
    {3'b100, 4'b1001, 4'b1010},  // R3 R4 entry 00
    {3'b111, 4'b1001, 4'b0101},  // R4 entry 11
    {3'b101, 4'b0110, 4'b1011},  // R4 hold
    {3'b110, 4'b1001, 4'b0110},  // R4 toggle 1->0
    {3'b110, 4'b1111, 4'b1101},  // R4 toggle 0->1
    {3'b101, 4'b0000, 4'b1011},  // R4 hold
    {3'b011, 4'b0000, 4'b0000},  // R2 load zeros
    {3'b101, 4'b1111, 4'b0000},  // R4 hold 0
    {3'b110, 4'b1111, 4'b0001},  // R4 toggle
    {3'b111, 4'b0000, 4'b0011},  // R3 set
    {3'b000, 4'b1111, 4'b1111},  // R1 load ones
    {3'b100, 4'b0110, 4'b1110},  // R3 reset entry
    {3'b100, 4'b0110, 4'b1100}   // R3 reset entry
  };

  logic       clk = 1'b0;
  logic       clr_n;
  logic       shift_en;
  logic       j_in;
  logic       k_n_in;
  logic [3:0] par_d;
  logic [3:0] q;
  logic       q_last_n;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  jk_shift4 u0 (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .j_in(j_in),
    .k_n_in(k_n_in), .par_d(par_d), .q(q), .q_last_n(q_last_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [3:0] exp);
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q actual %b expected %b", req, q, exp);
    end
    n_cmp++;
    if (q_last_n !== ~exp[3]) begin
      n_bad++;
      $display("FAIL R7 (%s): q_last_n actual %b expected %b", req, q_last_n, ~exp[3]);
    end
  endtask

  task automatic step(input logic s, input logic j, input logic kn, input logic [3:0] d);
    shift_en = s; j_in = j; k_n_in = kn; par_d = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    clr_n = 1'b0; shift_en = 1'b0; j_in = 1'b0; k_n_in = 1'b0; par_d = 4'hF;
    repeat (2) @(negedge clk);
    check("R5 reset state", 4'b0000);
    clr_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check($sformatf("R1/R3/R4 vector %0d", i), VEC[i][3:0]);
    end

    // R6: inputs move between edges, no edge occurs
    shift_en = 1'b0; par_d = 4'b0011; j_in = 1'b1; k_n_in = 1'b0;
    #1 par_d = 4'b0101; shift_en = 1'b1;
    #1 check("R6 hold without edge", 4'b1100);

    // R5: asynchronous clear mid-cycle
    step(1'b0, 1'b0, 1'b0, 4'b1111);
    check("R1 load before clear", 4'b1111);
    #2 clr_n = 1'b0;
    #1 check("R5 async clear", 4'b0000);

    // R8: edges while clear held
    step(1'b0, 1'b1, 1'b1, 4'b1111);
    check("R8 edge during clear", 4'b0000);
    step(1'b1, 1'b1, 1'b1, 4'b1111);
    check("R8 shift during clear", 4'b0000);
    clr_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'b0110);
    check("R8 first edge after release", 4'b0110);
    step(1'b1, 1'b1, 1'b0, 4'b0000);
    check("R4 toggle after release", 4'b1101);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule